// File: doc/BRIEF.md
# Virtual Interface Control Register

This block holds the state a hypervisor saves and restores when it switches a guest's virtual interrupt interface: a priority mask, two binary points, an end-of-interrupt split mode, a shared binary point mode, a fast-interrupt routing bit, a legacy acknowledge control bit and two group enables. The hypervisor reads and writes the whole 64-bit word through one port. Every field also appears as a separate output for the interrupt selection logic around it.

A narrow second port gives the guest's own view of the group 1 binary point. When shared binary point mode is on, this view is derived from the group 0 binary point, and guest writes to it are dropped. Binary point writes never store a value below a floor. The floor comes from the number of preemption bits that are implemented. For the group 1 binary point, the floor also depends on whether the hypervisor write is marked secure.

Top module: `virt_if_ctrl_reg`

## Requirements
- R1: Bits [63:32], [17:10] and [8:5] of `hv_rd_data` always read as zero, whatever value was written to them.
- R2: The word layout is: priority mask [31:24], group 0 binary point [23:21], group 1 binary point [20:18], EOI split bit 9, shared binary point bit 4, fast-interrupt routing bit 3, ack control bit 2, group 1 enable bit 1, group 0 enable bit 0. A hypervisor write with `hv_wr_en` high is visible on `hv_rd_data` and on the field outputs one clock later. With no write, the state holds.
- R3: A group 0 binary point written below BP0_MIN = 7 - PREEMPT_BITS (2 by default) is stored as BP0_MIN.
- R4: A hypervisor write with `hv_wr_secure` low stores a group 1 binary point of at least BP0_MIN + 1 (3 by default). A lower value is raised to that floor.
- R5: A hypervisor write with `hv_wr_secure` high stores a group 1 binary point of at least BP0_MIN. A lower value is raised to that floor.
- R6: `guest_bp1_rd` equals the stored group 1 binary point when shared mode is off. When shared mode is on, it equals the group 0 binary point plus one, saturated at 7.
- R7: A guest write (`guest_bp1_wr_en`) while shared mode is on leaves the stored group 1 binary point unchanged. Hypervisor writes to that field take effect whatever the mode.
- R8: A guest write while shared mode is off stores `guest_bp1_wr_data`, raised to the non-secure floor BP0_MIN + 1. If a hypervisor write happens in the same cycle, the hypervisor write wins.
- R9: With FORCE_SYSREG = 1, the fast-interrupt routing bit reads as 1 and the ack control bit reads as 0, on `hv_rd_data` and on the field outputs.
- R10: After reset, all fields are zero except the group 0 binary point, which is BP0_MIN, and the group 1 binary point, which is BP0_MIN + 1. By default this makes `hv_rd_data` equal to 0x00000000_004C0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hv_wr_en | input | 1 | Hypervisor full-word write strobe |
| hv_wr_secure | input | 1 | Marks the hypervisor write as secure (selects the group 1 floor) |
| hv_wr_data | input | 64 | Hypervisor write word |
| hv_rd_data | output | 64 | Hypervisor read word |
| guest_bp1_wr_en | input | 1 | Guest write strobe for the group 1 binary point |
| guest_bp1_wr_data | input | 3 | Guest group 1 binary point value |
| guest_bp1_rd | output | 3 | Guest view of the group 1 binary point |
| prio_mask | output | 8 | Priority mask |
| bp0 | output | 3 | Group 0 binary point |
| bp1 | output | 3 | Stored group 1 binary point |
| eoi_split | output | 1 | EOI split mode |
| common_bp | output | 1 | Shared binary point mode |
| fiq_en | output | 1 | Route group 0 as fast interrupts |
| ack_ctl | output | 1 | Legacy acknowledge control |
| grp1_en | output | 1 | Group 1 enable |
| grp0_en | output | 1 | Group 0 enable |

## Verification
The hardest situation to reach is a guest write that is dropped while shared mode is on. The guest view never shows the stored group 1 binary point in that mode, so the drop cannot be seen on the guest port. To observe it, the bench sets shared mode with a known stored value and sends guest writes. It then reads the stored field back through the hypervisor word. It also turns shared mode off again and checks that the guest view shows the untouched value. The saturation corner is reached by setting the group 0 binary point to 7 while shared mode is on.

// File: rtl/virt_if_ctrl_reg.sv
module virt_if_ctrl_reg #(
  parameter int PREEMPT_BITS = 5,
  parameter bit FORCE_SYSREG = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hv_wr_en,
  input  logic        hv_wr_secure,
  input  logic [63:0] hv_wr_data,
  output logic [63:0] hv_rd_data,
  input  logic        guest_bp1_wr_en,
  input  logic [2:0]  guest_bp1_wr_data,
  output logic [2:0]  guest_bp1_rd,
  output logic [7:0]  prio_mask,
  output logic [2:0]  bp0,
  output logic [2:0]  bp1,
  output logic        eoi_split,
  output logic        common_bp,
  output logic        fiq_en,
  output logic        ack_ctl,
  output logic        grp1_en,
  output logic        grp0_en
);

  localparam int BP0_MIN_I = 7 - PREEMPT_BITS;
  localparam int BP1_NS_I  = (BP0_MIN_I >= 7) ? 7 : BP0_MIN_I + 1;
  localparam logic [2:0] BP0_MIN   = 3'(BP0_MIN_I);
  localparam logic [2:0] BP1_MIN_NS = 3'(BP1_NS_I);

  logic [7:0] pmr_q;
  logic [2:0] bp0_q, bp1_q;
  logic       eoi_q, cbp_q, fiq_q, ack_q, g1_q, g0_q;

  function automatic logic [2:0] floor3(input logic [2:0] v, input logic [2:0] lo);
    return (v < lo) ? lo : v;
  endfunction

  logic [2:0] wr_bp0, wr_bp1, gst_bp1;
  assign wr_bp0  = floor3(hv_wr_data[23:21], BP0_MIN);
  assign wr_bp1  = floor3(hv_wr_data[20:18], hv_wr_secure ? BP0_MIN : BP1_MIN_NS);
  assign gst_bp1 = floor3(guest_bp1_wr_data, BP1_MIN_NS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmr_q <= '0;
      bp0_q <= BP0_MIN;
      bp1_q <= BP1_MIN_NS;
      eoi_q <= 1'b0;
      cbp_q <= 1'b0;
      fiq_q <= 1'b0;
      ack_q <= 1'b0;
      g1_q  <= 1'b0;
      g0_q  <= 1'b0;
    end else if (hv_wr_en) begin
      pmr_q <= hv_wr_data[31:24];
      bp0_q <= wr_bp0;
      bp1_q <= wr_bp1;
      eoi_q <= hv_wr_data[9];
      cbp_q <= hv_wr_data[4];
      fiq_q <= hv_wr_data[3];
      ack_q <= hv_wr_data[2];
      g1_q  <= hv_wr_data[1];
      g0_q  <= hv_wr_data[0];
    end else if (guest_bp1_wr_en && !cbp_q) begin
      bp1_q <= gst_bp1;
    end
  end

  assign prio_mask = pmr_q;
  assign bp0       = bp0_q;
  assign bp1       = bp1_q;
  assign eoi_split = eoi_q;
  assign common_bp = cbp_q;
  assign grp1_en   = g1_q;
  assign grp0_en   = g0_q;

  generate
    if (FORCE_SYSREG) begin : g_forced
      assign fiq_en  = 1'b1;
      assign ack_ctl = 1'b0;
    end else begin : g_free
      assign fiq_en  = fiq_q;
      assign ack_ctl = ack_q;
    end
  endgenerate

  assign guest_bp1_rd = !cbp_q ? bp1_q : ((bp0_q == 3'd7) ? 3'd7 : bp0_q + 3'd1);

  assign hv_rd_data = {32'd0, pmr_q, bp0_q, bp1_q, 8'd0, eoi_q, 4'd0,
                       cbp_q, fiq_en, ack_ctl, g1_q, g0_q};

  a_r3_bp0_floor: assert property (@(posedge clk) disable iff (!rst_n)
    bp0_q >= BP0_MIN);

  a_r4_ns_floor: assert property (@(posedge clk) disable iff (!rst_n)
    hv_wr_en && !hv_wr_secure |=> bp1 >= BP1_MIN_NS);

  a_r5_sec_floor: assert property (@(posedge clk) disable iff (!rst_n)
    hv_wr_en && hv_wr_secure |=> bp1 >= BP0_MIN);

  a_r7_guest_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    guest_bp1_wr_en && common_bp && !hv_wr_en |=> $stable(bp1));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_wr_en && !guest_bp1_wr_en |=> $stable(hv_rd_data));

  a_r6_guest_view_floor: assert property (@(posedge clk) disable iff (!rst_n)
    common_bp |-> guest_bp1_rd >= bp0);

endmodule

// File: tb/tb_virt_if_ctrl_reg.sv
module tb_virt_if_ctrl_reg;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, hv_wr_en, hv_wr_secure, guest_bp1_wr_en;
  logic [63:0] hv_wr_data, hv_rd_data, f_rd;
  logic [2:0]  guest_bp1_wr_data, guest_bp1_rd, bp0, bp1, f_g;
  logic [7:0]  prio_mask;
  logic        eoi_split, common_bp, fiq_en, ack_ctl, grp1_en, grp0_en;
  logic        f_fiq, f_ack;

  int checks = 0, fails = 0;

  virt_if_ctrl_reg dut (
    .clk, .rst_n, .hv_wr_en, .hv_wr_secure, .hv_wr_data, .hv_rd_data,
    .guest_bp1_wr_en, .guest_bp1_wr_data, .guest_bp1_rd, .prio_mask, .bp0, .bp1,
    .eoi_split, .common_bp, .fiq_en, .ack_ctl, .grp1_en, .grp0_en);

  virt_if_ctrl_reg #(.FORCE_SYSREG(1'b1)) dut_forced (
    .clk, .rst_n, .hv_wr_en, .hv_wr_secure, .hv_wr_data, .hv_rd_data(f_rd),
    .guest_bp1_wr_en, .guest_bp1_wr_data, .guest_bp1_rd(f_g), .prio_mask(),
    .bp0(), .bp1(), .eoi_split(), .common_bp(), .fiq_en(f_fiq), .ack_ctl(f_ack),
    .grp1_en(), .grp0_en());

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hv_write(input logic sec, input logic [63:0] d);
    @(negedge clk);
    hv_wr_en = 1'b1; hv_wr_secure = sec; hv_wr_data = d;
    @(negedge clk);
    hv_wr_en = 1'b0; hv_wr_secure = 1'b0;
  endtask

  task automatic guest_write(input logic [2:0] v);
    @(negedge clk);
    guest_bp1_wr_en = 1'b1; guest_bp1_wr_data = v;
    @(negedge clk);
    guest_bp1_wr_en = 1'b0;
  endtask

  // {secure, write data, expected read}
  localparam logic [128:0] VEC [8] = '{
    {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFC_021F},
    {1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_004C_0000},
    {1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0048_0000},
    {1'b0, 64'hDEAD_BEEF_A587_FFF5, 64'h0000_0000_A58C_0215},
    {1'b1, 64'hDEAD_BEEF_A587_FFF5, 64'h0000_0000_A588_0215},
    {1'b0, 64'h0000_0000_005C_0000, 64'h0000_0000_005C_0000},
    {1'b1, 64'h0000_0000_0068_000A, 64'h0000_0000_0068_000A},
    {1'b0, 64'h0000_0000_0068_000A, 64'h0000_0000_006C_000A}
  };

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hv_wr_en = 1'b0; hv_wr_secure = 1'b0; hv_wr_data = '0;
    guest_bp1_wr_en = 1'b0; guest_bp1_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset word", hv_rd_data, 64'h0000_0000_004C_0000);
    chk("R10 reset guest view", {61'd0, guest_bp1_rd}, 64'd3);

    // R1 R2 R3 R4 R5: vector walk
    for (int i = 0; i < 8; i++) begin
      hv_write(VEC[i][128], VEC[i][127:64]);
      chk("R1/R2/R3/R4/R5 vector word", hv_rd_data, VEC[i][63:0]);
    end

    // R2 field outputs against a known word
    hv_write(1'b0, 64'h0000_0000_3A9C_020B);
    chk("R2 prio_mask", {56'd0, prio_mask}, 64'h3A);
    chk("R2 bp0", {61'd0, bp0}, 64'd4);
    chk("R2 bp1", {61'd0, bp1}, 64'd7);
    chk("R2 flags", {58'd0, eoi_split, common_bp, fiq_en, ack_ctl, grp1_en, grp0_en},
        {58'd0, 6'b101011});
    chk("R2 hold", hv_rd_data, 64'h0000_0000_3A9C_020B);

    // R6 guest view, shared off
    chk("R6 guest view shared off", {61'd0, guest_bp1_rd}, 64'd7);
    // shared on, bp0=4, bp1=6
    hv_write(1'b0, 64'h0000_0000_0098_0010);
    chk("R6 guest view bp0+1", {61'd0, guest_bp1_rd}, 64'd5);
    // R7 guest write dropped
    guest_write(3'd3);
    chk("R7 guest write dropped", {61'd0, bp1}, 64'd6);
    chk("R7 word unchanged", hv_rd_data, 64'h0000_0000_0098_0010);
    // shared on, bp0=7: saturation
    hv_write(1'b0, 64'h0000_0000_00EC_0010);
    chk("R6 saturate at 7", {61'd0, guest_bp1_rd}, 64'd7);
    chk("R7 hv write in shared mode", {61'd0, bp1}, 64'd3);
    // shared off again: stored value visible
    hv_write(1'b0, 64'h0000_0000_0098_0000);
    chk("R6 guest view back to stored", {61'd0, guest_bp1_rd}, 64'd6);

    // R8 guest writes with shared off
    guest_write(3'd5);
    chk("R8 guest write stored", {61'd0, bp1}, 64'd5);
    guest_write(3'd0);
    chk("R8 guest write floored", {61'd0, bp1}, 64'd3);
    @(negedge clk);
    hv_wr_en = 1'b1; hv_wr_data = 64'h0000_0000_0098_0000;
    guest_bp1_wr_en = 1'b1; guest_bp1_wr_data = 3'd4;
    @(negedge clk);
    hv_wr_en = 1'b0; guest_bp1_wr_en = 1'b0;
    chk("R8 hv wins over guest", {61'd0, bp1}, 64'd6);

    // R9 forced variant
    hv_write(1'b0, 64'h0000_0000_0000_0000);
    chk("R9 forced fiq reads 1", {62'd0, f_fiq, f_ack}, 64'b10);
    hv_write(1'b0, 64'h0000_0000_0000_0004);
    chk("R9 forced word", f_rd, 64'h0000_0000_004C_0008);
    chk("R9 unforced word", hv_rd_data, 64'h0000_0000_004C_0004);

    // R10 reset again after activity
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R10 reset after activity", hv_rd_data, 64'h0000_0000_004C_0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule